// File: doc/BRIEF.md
# Gated Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A character written into a one-entry holding register moves into a frame serializer. The serializer sends a start bit, the data bits least significant first, an optional parity bit and a selectable stop length. Bit timing comes from a transmit clock input `txc`, which is sampled in the system clock domain. The line changes only after a falling edge of `txc` has been seen. Each bit lasts 1, 16 or 64 of those falling edges, as set by the rate factor. Both factor codes 00 and 01 give the x1 rate, where the bit rate equals the `txc` frequency.

New characters are accepted only while the transmit-enable command bit is high and the clear-to-send input `cts_n` is low. Removing either condition does not affect a character that was accepted earlier: it is still sent completely. A write made while the gate is closed is discarded, and the line stays at mark. `txrdy` shows that a write would be accepted. `txe` shows that nothing is held and nothing is being shifted. When a character is waiting at the end of the stop bits, its start bit follows at once, with no idle gap.

Top module: `gated_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `txe` is 1, and `txrdy` is 0 while `tx_en` is 0. The line stays at 1 whenever no frame is being shifted.
- R2: A frame is a start bit of 0, then the data bits of `wr_data` least significant first. The number of data bits is `char_len` + 5, so code 00 gives 5 bits and code 11 gives 8 bits. Unused upper bits are not sent.
- R3: When `par_en` is 1, a parity bit follows the data. It is the XOR of the sent data bits, XORed with `par_odd`: 0 selects even parity and 1 selects odd parity. When `par_en` is 0, no parity bit is sent.
- R4: The stop level is 1. Its length in units of the bit time F is set by `stop_sel`: 00 or 01 gives F, 10 gives F + F/2 (integer division), and 11 gives 2F.
- R5: Each start, data and parity bit lasts F falling edges of `txc`. F is 1 for `baud_sel` 00 or 01, 16 for 10, and 64 for 11. `txd` changes only in the clock cycle in which a falling edge of `txc` is detected.
- R6: `txrdy` is 1 exactly when `tx_en` is 1, `cts_n` is 0 and the holding register is empty. A write is accepted only in a cycle in which `txrdy` is 1.
- R7: A write made while `tx_en` is 0 or `cts_n` is 1 is discarded. Nothing is sent for it, and `txe` stays 1.
- R8: A character accepted before the gate closes, by either `tx_en` or `cts_n`, is still sent as a complete frame.
- R9: When a character is held at the end of the last stop interval, its start bit begins on that same `txc` falling edge, with no idle gap.
- R10: `txe` is 1 exactly when the holding register is empty and no frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txc | input | 1 | Transmit bit clock, sampled by `clk` |
| tx_en | input | 1 | Transmit-enable command bit |
| cts_n | input | 1 | Clear to send, active low |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel | input | 2 | Stop length code |
| baud_sel | input | 2 | Rate factor code (00 and 01: x1, 10: x16, 11: x64) |
| wr_en | input | 1 | Write strobe for a character |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial data, idles at 1 |
| txrdy | output | 1 | A write will be accepted |
| txe | output | 1 | Nothing held and nothing being shifted |

## Verification
Two events can land on the same clock edge: a write strobe, and a change of the enable gate. The bench drives `wr_en` together with the falling edge of `tx_en`, and again together with its rising edge. It judges the first case by `txe` staying 1 and the line staying at mark through the following bit times. It judges the second case by decoding a complete frame from the line. A second coincidence happens inside the serializer: the end of the stop interval meets a character that is already held. The bench provokes it by writing the next character while the current one is being shifted. It judges the result by the exact number of stop intervals between the two decoded frames.

// File: rtl/gtx_pkg.sv
package gtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } gtx_state_t;
endpackage

// File: rtl/gtx_edge.sv
module gtx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic txc,
  output logic fall
);
  logic txc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txc_q <= 1'b1;
    else        txc_q <= txc;
  end

  assign fall = txc_q & ~txc;
endmodule

// File: rtl/gtx_hold.sv
module gtx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          gate_open,
  input  logic          take,
  output logic          hold_valid,
  output logic [DW-1:0] hold_data
);
  logic          accept;
  logic          valid_n;
  logic [DW-1:0] data_n;

  assign accept = wr_en & gate_open & ~hold_valid;

  always_comb begin
    valid_n = hold_valid;
    data_n  = hold_data;
    if (take)   valid_n = 1'b0;
    if (accept) begin
      valid_n = 1'b1;
      data_n  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else begin
      hold_valid <= valid_n;
      if (accept) hold_data <= data_n;
    end
  end
endmodule

// File: rtl/gtx_serial.sv
module gtx_serial
  import gtx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LOF = 16,
  parameter int HIF = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          hold_valid,
  input  logic [DW-1:0] hold_data,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [1:0]    stop_sel,
  input  logic [1:0]    baud_sel,
  output logic          take,
  output logic          txd,
  output logic          idle
);
  localparam int CW = $clog2(2 * HIF);
  localparam int SW = DW + 1;
  localparam int BW = $clog2(SW + 1);

  gtx_state_t    state, state_n;
  logic [CW-1:0] cnt, cnt_n, fm1_q, fm1_n, sm1_q, sm1_n;
  logic [SW-1:0] sreg, sreg_n, frame;
  logic [BW-1:0] left, left_n;
  logic          txd_n;
  logic [CW-1:0] f_m1, s_m1;
  logic [3:0]    ndat;
  logic [DW-1:0] dmask, dm;
  logic          par;

  always_comb begin
    case (baud_sel)
      2'b10:   f_m1 = CW'(LOF - 1);
      2'b11:   f_m1 = CW'(HIF - 1);
      default: f_m1 = '0;
    endcase
    case (stop_sel)
      2'b10:   s_m1 = CW'(f_m1 + ((f_m1 + 1'b1) >> 1));
      2'b11:   s_m1 = CW'({f_m1, 1'b1});
      default: s_m1 = f_m1;
    endcase
  end

  assign ndat = 4'd5 + {2'b00, char_len};

  always_comb begin
    for (int k = 0; k < DW; k++) dmask[k] = (k < int'(ndat));
    dm  = hold_data & dmask;
    par = (^dm) ^ par_odd;
    frame = {1'b0, dm};
    for (int k = 0; k < SW; k++)
      if (par_en && (k == int'(ndat))) frame[k] = par;
  end

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sreg_n  = sreg;
    left_n  = left;
    txd_n   = txd;
    fm1_n   = fm1_q;
    sm1_n   = sm1_q;
    take    = 1'b0;
    if (fall) begin
      case (state)
        ST_IDLE: begin
          txd_n = 1'b1;
        end
        ST_START: begin
          if (cnt != '0) cnt_n = cnt - 1'b1;
          else begin
            state_n = ST_DATA;
            txd_n   = sreg[0];
            cnt_n   = fm1_q;
          end
        end
        ST_DATA: begin
          if (cnt != '0) cnt_n = cnt - 1'b1;
          else if (left == '0) begin
            state_n = ST_STOP;
            txd_n   = 1'b1;
            cnt_n   = sm1_q;
          end else begin
            sreg_n = sreg >> 1;
            txd_n  = sreg[1];
            left_n = left - 1'b1;
            cnt_n  = fm1_q;
          end
        end
        default: begin
          if (cnt != '0) cnt_n = cnt - 1'b1;
          else begin
            state_n = ST_IDLE;
            txd_n   = 1'b1;
          end
        end
      endcase
      if (hold_valid && (state == ST_IDLE ||
          (state == ST_STOP && cnt == '0))) begin
        take    = 1'b1;
        state_n = ST_START;
        txd_n   = 1'b0;
        cnt_n   = f_m1;
        fm1_n   = f_m1;
        sm1_n   = s_m1;
        sreg_n  = frame;
        left_n  = BW'(ndat + {3'b000, par_en} - 4'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sreg  <= '0;
      left  <= '0;
      txd   <= 1'b1;
      fm1_q <= '0;
      sm1_q <= '0;
    end else if (fall) begin
      state <= state_n;
      cnt   <= cnt_n;
      sreg  <= sreg_n;
      left  <= left_n;
      txd   <= txd_n;
      fm1_q <= fm1_n;
      sm1_q <= sm1_n;
    end
  end

  assign idle = (state == ST_IDLE);
endmodule

// File: rtl/gated_uart_tx.sv
module gated_uart_tx #(
  parameter int DW  = 8,
  parameter int LOF = 16,
  parameter int HIF = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txc,
  input  logic          tx_en,
  input  logic          cts_n,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [1:0]    stop_sel,
  input  logic [1:0]    baud_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          txrdy,
  output logic          txe
);
  logic [1:0]    rst_pipe;
  logic          rst_sn;
  logic          fall;
  logic          gate_open;
  logic          take;
  logic          hold_valid;
  logic [DW-1:0] hold_data;
  logic          ser_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign gate_open = tx_en & ~cts_n;

  gtx_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sn),
    .txc   (txc),
    .fall  (fall)
  );

  gtx_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .gate_open  (gate_open),
    .take       (take),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  gtx_serial #(.DW(DW), .LOF(LOF), .HIF(HIF)) u_ser (
    .clk        (clk),
    .rst_n      (rst_sn),
    .fall       (fall),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .char_len   (char_len),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .stop_sel   (stop_sel),
    .baud_sel   (baud_sel),
    .take       (take),
    .txd        (txd),
    .idle       (ser_idle)
  );

  assign txrdy = gate_open & ~hold_valid;
  assign txe   = ~hold_valid & ser_idle;
endmodule

// File: rtl/gtx_check.sv
module gtx_check (
  input logic clk,
  input logic rst_n,
  input logic fall,
  input logic txd,
  input logic txrdy,
  input logic txe,
  input logic tx_en,
  input logic cts_n,
  input logic wr_en,
  input logic idle
);
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> txd);

  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(txd));

  a_r6_rdy_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    txrdy |-> (tx_en && !cts_n));

  a_r7_closed_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(tx_en && !cts_n) && txe) |=> txe);

  a_r10_empty_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    txe |-> txd);
endmodule

bind gated_uart_tx gtx_check u_chk (
  .clk   (clk),
  .rst_n (rst_sn),
  .fall  (fall),
  .txd   (txd),
  .txrdy (txrdy),
  .txe   (txe),
  .tx_en (tx_en),
  .cts_n (cts_n),
  .wr_en (wr_en),
  .idle  (ser_idle)
);

// File: tb/sim_gated_uart_tx.sv
`timescale 1ns/1ps
module sim_gated_uart_tx;
  localparam int LOGN = 4096;

  logic clk, rst_n, txc, tx_en, cts_n, par_en, par_odd, wr_en;
  logic [1:0] char_len, stop_sel, baud_sel;
  logic [7:0] wr_data;
  logic txd, txrdy, txe;

  int checks = 0;
  int errors = 0;
  logic log_t [0:LOGN-1];
  int nlog = 0;
  int ph = 0;
  bit done = 0;

  gated_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .txc(txc), .tx_en(tx_en), .cts_n(cts_n),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .stop_sel(stop_sel), .baud_sel(baud_sel), .wr_en(wr_en),
    .wr_data(wr_data), .txd(txd), .txrdy(txrdy), .txe(txe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial txc = 1'b1;
  always @(negedge clk) begin
    ph  = (ph + 1) % 4;
    txc = (ph < 2);
    if (ph == 3 && nlog < LOGN) begin
      log_t[nlog] = txd;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input logic [1:0] cl, input logic pe, input logic po,
                          input logic [1:0] ss, input logic [1:0] bs);
    char_len = cl; par_en = pe; par_odd = po; stop_sel = ss; baud_sel = bs;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic write_ready(input logic [7:0] d);
    while (!txrdy) step();
    pulse_wr(d);
  endtask

  task automatic wait_idle();
    while (!txe) step();
    repeat (8) step();
  endtask

  task automatic wait_log(input int n);
    while (nlog < n) step();
  endtask

  function automatic int find_start(input int from);
    for (int k = from; k < nlog; k++)
      if (log_t[k] == 1'b0) return k;
    return -1;
  endfunction

  task automatic chk_frame(input string req, input int i, input int nd,
                           input int pe, input int po, input int f, input int sl,
                           input logic [7:0] d, input bit nxt);
    logic [7:0] got, dm;
    logic exp_par;
    int s0, ones;
    s0 = i + f * (1 + nd + pe);
    wait_log(s0 + sl + 2);
    dm = 8'h00;
    for (int j = 0; j < nd; j++) dm[j] = d[j];
    check(log_t[i] == 1'b0 && log_t[i+f-1] == 1'b0, req, "start bit spans F",
          int'(log_t[i+f-1]), 0);
    check(log_t[i+f] == dm[0], req, "first data bit at F", int'(log_t[i+f]), int'(dm[0]));
    got = 8'h00;
    for (int j = 0; j < nd; j++) got[j] = log_t[i + f * (1 + j) + f / 2];
    check(got == dm, req, "data bits", int'(got), int'(dm));
    if (pe != 0) begin
      exp_par = (^dm) ^ po[0];
      check(log_t[i + f * (1 + nd) + f / 2] == exp_par, "R3", "parity bit",
            int'(log_t[i + f * (1 + nd) + f / 2]), int'(exp_par));
    end
    ones = 0;
    for (int k = 0; k < sl; k++) if (log_t[s0 + k] == 1'b1) ones++;
    check(ones == sl, "R4", "stop interval at mark", ones, sl);
    check(log_t[s0 + sl] == !nxt, nxt ? "R9" : "R1",
          "entry after stop", int'(log_t[s0 + sl]), int'(!nxt));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_en = 1'b0; cts_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    set_mode(2'b11, 1'b0, 1'b0, 2'b01, 2'b01);
    repeat (5) step();
    rst_n = 1'b1;
    repeat (6) step();
    check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(txe == 1'b1, "R1", "txe after reset", int'(txe), 1);
    check(txrdy == 1'b0, "R1", "txrdy with enable low", int'(txrdy), 0);
  endtask

  task automatic t_basic();
    int i;
    set_mode(2'b11, 1'b0, 1'b0, 2'b01, 2'b01);
    tx_en = 1'b1; cts_n = 1'b0;
    step();
    check(txrdy == 1'b1, "R6", "txrdy with gate open", int'(txrdy), 1);
    nlog = 0;
    pulse_wr(8'hA5);
    check(txrdy == 1'b0, "R6", "txrdy while held", int'(txrdy), 0);
    check(txe == 1'b0, "R10", "txe while held", int'(txe), 0);
    wait_log(4);
    i = find_start(0);
    check(i >= 0, "R2", "start bit found", i, 0);
    if (i >= 0) chk_frame("R2", i, 8, 0, 0, 1, 1, 8'hA5, 1'b0);
    wait_idle();
    check(txe == 1'b1, "R10", "txe after frame", int'(txe), 1);
  endtask

  task automatic t_pair(input string req, input logic [1:0] cl, input logic pe,
                        input logic po, input logic [1:0] ss, input logic [1:0] bs,
                        input int f, input int sl, input logic [7:0] d0,
                        input logic [7:0] d1);
    int i;
    set_mode(cl, pe, po, ss, bs);
    tx_en = 1'b1; cts_n = 1'b0;
    wait_idle();
    nlog = 0;
    write_ready(d0);
    write_ready(d1);
    wait_log(f + 2);
    i = find_start(0);
    check(i >= 0, req, "first start found", i, 0);
    if (i >= 0) begin
      chk_frame(req, i, 5 + int'(cl), int'(pe), int'(po), f, sl, d0, 1'b1);
      chk_frame(req, i + f * (1 + 5 + int'(cl) + int'(pe)) + sl,
                5 + int'(cl), int'(pe), int'(po), f, sl, d1, 1'b0);
    end
    wait_idle();
  endtask

  task automatic t_disable();
    int i, marks;
    set_mode(2'b11, 1'b0, 1'b0, 2'b01, 2'b01);
    tx_en = 1'b1; cts_n = 1'b0;
    wait_idle();
    nlog = 0;
    pulse_wr(8'h96);
    tx_en = 1'b0;
    wait_log(4);
    i = find_start(0);
    check(i >= 0, "R8", "held frame starts after disable", i, 0);
    if (i >= 0) chk_frame("R8", i, 8, 0, 0, 1, 1, 8'h96, 1'b0);
    wait_idle();
    check(txrdy == 1'b0, "R6", "txrdy with enable low", int'(txrdy), 0);
    nlog = 0;
    pulse_wr(8'h00);
    check(txe == 1'b1, "R7", "txe after write by command gate", int'(txe), 1);
    tx_en = 1'b1; cts_n = 1'b1;
    step();
    pulse_wr(8'h00);
    check(txe == 1'b1, "R7", "txe after write by cts gate", int'(txe), 1);
    wait_log(nlog + 30);
    marks = 0;
    for (int k = 0; k < nlog; k++) if (log_t[k] == 1'b1) marks++;
    check(marks == nlog, "R7", "line at mark after closed writes", marks, nlog);
    cts_n = 1'b0;
    step();
  endtask

  task automatic t_same_cycle();
    int i, marks;
    set_mode(2'b10, 1'b1, 1'b1, 2'b01, 2'b01);
    tx_en = 1'b1; cts_n = 1'b0;
    wait_idle();
    nlog = 0;
    tx_en = 1'b0;
    pulse_wr(8'h3F);
    check(txe == 1'b1, "R7", "write with disable same cycle", int'(txe), 1);
    wait_log(12);
    marks = 0;
    for (int k = 0; k < nlog; k++) if (log_t[k] == 1'b1) marks++;
    check(marks == nlog, "R7", "no frame for same-cycle write", marks, nlog);
    nlog = 0;
    tx_en = 1'b1;
    pulse_wr(8'h2D);
    check(txe == 1'b0, "R6", "write with enable same cycle accepted", int'(txe), 0);
    wait_log(4);
    i = find_start(0);
    check(i >= 0, "R6", "frame after same-cycle enable", i, 0);
    if (i >= 0) chk_frame("R2", i, 7, 1, 1, 1, 1, 8'h2D, 1'b0);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_pair("R5", 2'b10, 1'b1, 1'b0, 2'b01, 2'b10, 16, 16, 8'h3C, 8'h31);
    t_pair("R9", 2'b00, 1'b1, 1'b1, 2'b10, 2'b10, 16, 24, 8'h1B, 8'h04);
    t_pair("R4", 2'b01, 1'b0, 1'b0, 2'b11, 2'b11, 64, 128, 8'h2A, 8'h15);
    t_pair("R2", 2'b11, 1'b0, 1'b0, 2'b11, 2'b00, 1, 2, 8'hC3, 8'h7E);
    t_disable();
    t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule